// File: doc/BRIEF.md
# Static Memory Bus Timing Controller

This block turns single read and write requests from an internal requester into timed cycles on an external asynchronous memory bus. It drives one chip-select line per bank, an active-low output enable, an active-low write enable, four byte-lane strobes, the address and the write data. It captures read data from the bus at the end of the access. Each bank has its own timing fields: the delay from chip select to write strobe, the delay from chip select to output enable, the first-access and in-page read waits, the write wait, and the bus turnaround. Each bank also has its own chip-select and lane-strobe polarity, a memory width, a page-mode switch and an external-wait switch. One shared field sets the timeout for the external wait.

A request is taken when `req_valid` and `req_ready` are both high. The controller then runs one external cycle, made of an optional turnaround gap, a setup phase and a strobe phase. It reports completion with a one-cycle `rsp_valid`. The next request can be presented in that same cycle. The configuration inputs must stay stable while `busy` is high.

Top module: `smc_timing`

## Requirements
- R1: After reset, `busy` and `rsp_valid` are 0, `mem_oe_n` and `mem_we_n` are 1, and every chip-select line sits at its inactive level (the complement of its polarity bit).
- R2: `req_ready` equals `en` while idle and is 0 while busy. With `en` low, no request is accepted and the bus stays inactive.
- R3: A write asserts the selected chip select for (we_dly+1) cycles before `mem_we_n` goes low. `mem_we_n` then stays low, with `mem_dout_en` high, for (wr_wait+2) cycles. Chip select is released together with the write strobe.
- R4: A read that is not a page hit asserts chip select for oe_dly cycles before `mem_oe_n` goes low; a value of 0 means both go active together. `mem_oe_n` then stays low for (rd_wait+1) cycles.
- R5: A page hit is a read on a bank with page mode on, whose previous completed access was a read on the same bank and within the same 16-byte page (same address bits above bit 3). A page hit skips the setup phase and holds `mem_oe_n` low for (pg_wait+1) cycles.
- R6: A gap of (turn+1) cycles with every chip select inactive comes before an access whose direction or bank differs from the previous completed access. No gap is inserted otherwise, and none before the first access after reset.
- R7: A chip-select polarity bit of 0 makes that line active low; a value of 1 makes it active high. At most one line is active at a time.
- R8: During the strobe phase, the active lanes are `req_be` masked by the width: width code 0 (8-bit) gives lane 0, code 1 (16-bit) gives lanes 1:0, and codes 2 (32-bit) and 3 (reserved) give all four lanes. With the lane polarity bit 0, active lanes are driven 1 on reads and 0 on writes. With the bit at 1, active lanes are driven 0 for both. Inactive lanes take the opposite level.
- R9: With external wait enabled on the bank, a high `mem_wait` at the end of the last nominal strobe cycle extends the strobe one cycle at a time. The access ends at the first edge where `mem_wait` is low. With external wait disabled, `mem_wait` has no effect.
- R10: An extension lasts at most 16*(to+1) cycles. If `mem_wait` is still high after that, the access ends with `rsp_err` = 1.
- R11: `rsp_valid` pulses for one cycle right after the last strobe cycle. On reads, `rsp_rdata` holds `mem_din` as sampled at the edge that ends the strobe. `rsp_err` is 0 unless R10 applies.
- R12: `busy` is high from the cycle after acceptance through the last strobe cycle. `mem_addr` and `mem_dout` hold the request's address and data for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Global enable for accepting requests |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | SW | Bank index |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables |
| req_ready | output | 1 | Request can be taken this cycle |
| rsp_valid | output | 1 | Access completed |
| rsp_err | output | 1 | Access ended by wait timeout |
| rsp_rdata | output | 32 | Read data |
| busy | output | 1 | Access in progress |
| cfg_we_dly | input | NCS*4 | Per bank: CS-to-write-strobe delay field |
| cfg_oe_dly | input | NCS*4 | Per bank: CS-to-output-enable delay field |
| cfg_rd_wait | input | NCS*5 | Per bank: first/non-page read wait field |
| cfg_pg_wait | input | NCS*5 | Per bank: in-page read wait field |
| cfg_wr_wait | input | NCS*5 | Per bank: write wait field |
| cfg_turn | input | NCS*4 | Per bank: turnaround field |
| cfg_cs_pol | input | NCS | Per bank: chip-select polarity |
| cfg_bl_pol | input | NCS | Per bank: lane-strobe polarity |
| cfg_width | input | NCS*2 | Per bank: memory width code |
| cfg_page_en | input | NCS | Per bank: page mode enable |
| cfg_xwait_en | input | NCS | Per bank: external wait enable |
| cfg_xwait_to | input | 10 | Shared external wait timeout field |
| mem_cs | output | NCS | Chip selects |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bls | output | 4 | Byte-lane strobes |
| mem_addr | output | AW | Memory address |
| mem_dout | output | 32 | Write data to memory |
| mem_dout_en | output | 1 | Data bus drive enable |
| mem_din | input | 32 | Read data from memory |
| mem_wait | input | 1 | External wait, high = hold |

## Verification
The bench targets the off-by-one offsets of the timing fields. A design that mixed up the n, n+1 and n+2 offsets would show strobes one cycle early or late. It also targets the zero-length setup of a page hit and of a zero output-enable delay, where a design that forgot to skip the phase would hold chip select alone for a stray cycle. It covers the turnaround rule: a design that inserted the gap on every access, or only on a direction change, would miss the expected cycle on same-direction repeats or on bank switches. It drives extensions exactly at the timeout limit and one beyond it, where a counter off by one would report a false error or miss a real one. It also covers reserved width codes and `mem_wait` toggling on a bank with waiting disabled.

// File: rtl/smc_timing.sv
module smc_timing #(
  parameter int NCS = 2,
  parameter int AW = 20,
  localparam int SW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [SW-1:0]   req_cs,
  input  logic [AW-1:0]   req_addr,
  input  logic [31:0]     req_wdata,
  input  logic [3:0]      req_be,
  output logic            req_ready,
  output logic            rsp_valid,
  output logic            rsp_err,
  output logic [31:0]     rsp_rdata,
  output logic            busy,
  input  logic [NCS*4-1:0] cfg_we_dly,
  input  logic [NCS*4-1:0] cfg_oe_dly,
  input  logic [NCS*5-1:0] cfg_rd_wait,
  input  logic [NCS*5-1:0] cfg_pg_wait,
  input  logic [NCS*5-1:0] cfg_wr_wait,
  input  logic [NCS*4-1:0] cfg_turn,
  input  logic [NCS-1:0]   cfg_cs_pol,
  input  logic [NCS-1:0]   cfg_bl_pol,
  input  logic [NCS*2-1:0] cfg_width,
  input  logic [NCS-1:0]   cfg_page_en,
  input  logic [NCS-1:0]   cfg_xwait_en,
  input  logic [9:0]       cfg_xwait_to,
  output logic [NCS-1:0]   mem_cs,
  output logic            mem_oe_n,
  output logic            mem_we_n,
  output logic [3:0]      mem_bls,
  output logic [AW-1:0]   mem_addr,
  output logic [31:0]     mem_dout,
  output logic            mem_dout_en,
  input  logic [31:0]     mem_din,
  input  logic            mem_wait
);

  typedef enum logic [1:0] {S_IDLE, S_TURN, S_SETUP, S_ACC} st_t;

  st_t st;
  logic [5:0]    cnt;
  logic [14:0]   xcnt;
  logic          wr, pv, pwr;
  logic [SW-1:0] sel, psel;
  logic [AW-1:0] addr;
  logic [AW-5:0] ppage;
  logic [31:0]   wdata;
  logic [3:0]    be;

  wire idle = (st == S_IDLE);
  wire           c_wr   = idle ? req_write : wr;
  wire [SW-1:0]  c_sel  = idle ? req_cs : sel;
  wire [AW-5:0]  c_page = idle ? req_addr[AW-1:4] : addr[AW-1:4];

  wire hit = pv && !pwr && !c_wr && (psel == c_sel) && (ppage == c_page) && cfg_page_en[c_sel];
  wire need_turn = pv && ((pwr != c_wr) || (psel != c_sel));

  wire [5:0] setup_len = c_wr ? 6'(cfg_we_dly[int'(c_sel)*4 +: 4]) + 6'd1
                       : hit  ? 6'd0 : 6'(cfg_oe_dly[int'(c_sel)*4 +: 4]);
  wire [5:0] acc_len = c_wr ? 6'(cfg_wr_wait[int'(c_sel)*5 +: 5]) + 6'd2
                     : hit  ? 6'(cfg_pg_wait[int'(c_sel)*5 +: 5]) + 6'd1
                            : 6'(cfg_rd_wait[int'(c_sel)*5 +: 5]) + 6'd1;
  wire turn_last  = (cnt == 6'(cfg_turn[int'(c_sel)*4 +: 4]));
  wire setup_last = (cnt == setup_len - 6'd1);
  wire acc_done   = (cnt == acc_len - 6'd1);
  wire [10:0] to_p1 = {1'b0, cfg_xwait_to} + 11'd1;
  wire [14:0] xlim  = {to_p1, 4'b0000};
  wire xw = cfg_xwait_en[sel] && mem_wait;
  wire [1:0] wd = cfg_width[int'(sel)*2 +: 2];
  wire [3:0] wmask = (wd == 2'd0) ? 4'b0001 : (wd == 2'd1) ? 4'b0011 : 4'b1111;
  wire [3:0] lanes = (st == S_ACC) ? (be & wmask) : 4'b0000;
  wire st_after_turn = (setup_len != 6'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; xcnt <= '0;
      wr <= 1'b0; sel <= '0; addr <= '0; wdata <= '0; be <= '0;
      pv <= 1'b0; pwr <= 1'b0; psel <= '0; ppage <= '0;
      rsp_valid <= 1'b0; rsp_err <= 1'b0; rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (en && req_valid) begin
          wr <= req_write; sel <= req_cs; addr <= req_addr;
          wdata <= req_wdata; be <= req_be;
          cnt <= '0; xcnt <= '0;
          st <= need_turn ? S_TURN : (st_after_turn ? S_SETUP : S_ACC);
        end
        S_TURN: if (turn_last) begin
          cnt <= '0;
          st <= st_after_turn ? S_SETUP : S_ACC;
        end else cnt <= cnt + 6'd1;
        S_SETUP: if (setup_last) begin
          cnt <= '0;
          st <= S_ACC;
        end else cnt <= cnt + 6'd1;
        default: if (!acc_done) cnt <= cnt + 6'd1;
        else if (xw && (xcnt != xlim)) xcnt <= xcnt + 15'd1;
        else begin
          st <= S_IDLE;
          rsp_valid <= 1'b1;
          rsp_err <= xw;
          if (!wr) rsp_rdata <= mem_din;
          pv <= 1'b1; pwr <= wr; psel <= sel; ppage <= addr[AW-1:4];
        end
      endcase
    end
  end

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign mem_cs[i] = ((st == S_SETUP || st == S_ACC) && sel == SW'(i)) ? cfg_cs_pol[i] : ~cfg_cs_pol[i];
  end

  assign req_ready   = en && idle;
  assign busy        = !idle;
  assign mem_oe_n    = !(st == S_ACC && !wr);
  assign mem_we_n    = !(st == S_ACC && wr);
  assign mem_dout_en = (st == S_ACC) && wr;
  assign mem_bls     = (wr || cfg_bl_pol[sel]) ? ~lanes : lanes;
  assign mem_addr    = addr;
  assign mem_dout    = wdata;

  wire [NCS-1:0] cs_on = ~(mem_cs ^ cfg_cs_pol);

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
  assert_cs_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cs_on) <= 1);
  assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !busy) |=> !busy);
  assert_accept_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);
  assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_err_needs_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> cfg_xwait_en[sel]);
  assert_addr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(mem_addr) && $stable(mem_dout)));

endmodule

// File: tb/tb_smc_timing.sv
module tb_smc_timing;
  localparam int NCS = 2;
  localparam int AW = 20;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [0:0] req_cs = '0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0] req_be = '0;
  logic req_ready, rsp_valid, rsp_err, busy, mem_oe_n, mem_we_n, mem_dout_en;
  logic [31:0] rsp_rdata, mem_dout;
  logic [31:0] mem_din = '0;
  logic mem_wait = 1'b0;
  logic [NCS-1:0] mem_cs;
  logic [3:0] mem_bls;
  logic [AW-1:0] mem_addr;
  logic [NCS*4-1:0] we_d, oe_d, trn;
  logic [NCS*5-1:0] rd_w, pg_w, wr_w;
  logic [NCS-1:0] csp, blp, pge, xen;
  logic [NCS*2-1:0] wid;
  logic [9:0] xto;

  int checks = 0, failures = 0;
  bit done = 0;
  bit pv = 0, pwr = 0;
  int psel = 0;
  logic [AW-5:0] ppage = '0;

  always #2 clk = ~clk;

  smc_timing #(.NCS(NCS), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .req_valid(req_valid), .req_write(req_write),
    .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .busy(busy), .cfg_we_dly(we_d), .cfg_oe_dly(oe_d), .cfg_rd_wait(rd_w),
    .cfg_pg_wait(pg_w), .cfg_wr_wait(wr_w), .cfg_turn(trn), .cfg_cs_pol(csp),
    .cfg_bl_pol(blp), .cfg_width(wid), .cfg_page_en(pge), .cfg_xwait_en(xen),
    .cfg_xwait_to(xto), .mem_cs(mem_cs), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_bls(mem_bls), .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
    .mem_din(mem_din), .mem_wait(mem_wait));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [10:0] expv(input int ph, input bit w, input int cs,
                                       input logic [3:0] b, input bit bsy, input bit rv);
    logic [1:0] csv;
    logic [3:0] wm, ln;
    logic [1:0] wc;
    for (int i = 0; i < NCS; i++) begin
      bit a = (ph == 1 || ph == 2) && (i == cs);
      csv[i] = a ? csp[i] : ~csp[i];
    end
    wc = wid[cs*2 +: 2];
    wm = (wc == 2'd0) ? 4'b0001 : (wc == 2'd1) ? 4'b0011 : 4'b1111;
    ln = (ph == 2) ? (b & wm) : 4'b0000;
    return {csv, !(ph == 2 && !w), !(ph == 2 && w), (w || blp[cs]) ? ~ln : ln,
            (ph == 2 && w), bsy, rv};
  endfunction

  function automatic logic [10:0] actv();
    return {mem_cs, mem_oe_n, mem_we_n, mem_bls, mem_dout_en, busy, rsp_valid};
  endfunction

  task automatic do_op(input bit w, input int cs, input logic [AW-1:0] a, input logic [31:0] d,
                       input logic [3:0] b, input int hold, input string tag);
    bit hit, turn, err;
    int tn, s, acc, e, lim, total;
    lim = 16 * (int'(xto) + 1);
    hit = pv && !pwr && !w && psel == cs && ppage == a[AW-1:4] && pge[cs];
    turn = pv && (pwr != w || psel != cs);
    tn = turn ? int'(trn[cs*4 +: 4]) + 1 : 0;
    s = w ? int'(we_d[cs*4 +: 4]) + 1 : hit ? 0 : int'(oe_d[cs*4 +: 4]);
    acc = w ? int'(wr_w[cs*5 +: 5]) + 2 : hit ? int'(pg_w[cs*5 +: 5]) + 1 : int'(rd_w[cs*5 +: 5]) + 1;
    e = !xen[cs] ? 0 : (hold > lim ? lim : hold);
    err = xen[cs] && hold > lim;
    total = tn + s + acc + e;
    req_valid = 1; req_write = w; req_cs = 1'(cs); req_addr = a; req_wdata = d; req_be = b;
    mem_din = ~d; mem_wait = 0;
    chk(req_ready == 1'b1, "R2 ready when idle", 64'(req_ready), 64'd1);
    for (int c = 0; c < total; c++) begin
      int ph, k;
      @(negedge clk);
      if (c == 0) req_valid = 0;
      ph = (c < tn) ? 0 : (c < tn + s) ? 1 : 2;
      k = c - tn - s;
      chk(actv() == expv(ph, w, cs, b, 1, 0), tag, 64'(actv()), 64'(expv(ph, w, cs, b, 1, 0)));
      mem_wait = (ph == 2) && (k < acc - 1 + hold);
    end
    @(negedge clk);
    mem_wait = 0;
    chk(actv() == expv(-1, w, cs, b, 0, 1), "R11 completion", 64'(actv()), 64'(expv(-1, w, cs, b, 0, 1)));
    chk(rsp_err == err, "R10 error flag", 64'(rsp_err), 64'(err));
    chk(mem_addr == a && mem_dout == d, "R12 address/data held", {mem_addr, mem_dout}, {a, d});
    if (!w) chk(rsp_rdata == ~d, "R11 read data", 64'(rsp_rdata), 64'(~d));
    pv = 1; pwr = w; psel = cs; ppage = a[AW-1:4];
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    we_d = {4'd0, 4'd2}; oe_d = {4'd0, 4'd1}; rd_w = {5'd0, 5'd3}; pg_w = {5'd0, 5'd1};
    wr_w = {5'd0, 5'd2}; trn = {4'd0, 4'd2}; csp = 2'b10; blp = 2'b10; wid = {2'd0, 2'd2};
    pge = 2'b01; xen = 2'b10; xto = 10'd0;
    repeat (3) @(negedge clk);
    chk(actv() == expv(-1, 0, 0, 4'h0, 0, 0), "R1 reset outputs", 64'(actv()), 64'(expv(-1, 0, 0, 4'h0, 0, 0)));
    rst_n = 1;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_cs = 0; req_be = 4'hF;
    chk(req_ready == 1'b0, "R2 disabled not ready", 64'(req_ready), 64'd0);
    repeat (3) @(negedge clk);
    chk(actv() == expv(-1, 0, 0, 4'h0, 0, 0), "R2 disabled stays idle", 64'(actv()), 64'(expv(-1, 0, 0, 4'h0, 0, 0)));
    req_valid = 0; en = 1;
    @(negedge clk);
    do_op(1, 0, 20'h00100, 32'h1111_2222, 4'hF, 0, "R3 write timing");
    do_op(0, 0, 20'h00100, 32'h3333_4444, 4'hF, 0, "R6 R4 turn then read");
    do_op(0, 0, 20'h00104, 32'h5555_6666, 4'hF, 0, "R5 page hit");
    do_op(0, 0, 20'h00020, 32'h7777_8888, 4'hF, 0, "R5 page miss R4");
    do_op(1, 1, 20'h00040, 32'h0A0B_0C0D, 4'b0011, 0, "R7 R8 8-bit write bank1");
    do_op(1, 1, 20'h00044, 32'h1234_5678, 4'hF, 5, "R9 extended write");
    do_op(0, 1, 20'h00048, 32'h9ABC_DEF0, 4'hF, 16, "R9 R10 extension at limit");
    do_op(0, 1, 20'h0004C, 32'h0F0F_F0F0, 4'hF, 40, "R10 timeout");
    do_op(0, 0, 20'h00108, 32'hCAFE_0001, 4'hF, 3, "R6 R9 bank change, wait ignored");
    wid = {2'd0, 2'd1};
    do_op(1, 0, 20'h00200, 32'hCAFE_0002, 4'hF, 0, "R8 16-bit lanes");
    wid = {2'd0, 2'd3};
    do_op(1, 0, 20'h00204, 32'hCAFE_0003, 4'b1010, 0, "R8 reserved width");
    do_op(0, 0, 20'h00204, 32'hCAFE_0004, 4'hF, 0, "R5 no hit after write");
    do_op(0, 0, 20'h00208, 32'hCAFE_0005, 4'hF, 0, "R5 hit back to back");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule